// File: doc/BRIEF.md
# External Bus Idle Cycle Inserter

This block sits in an external bus controller, between the sequencer that issues access requests and the state machine that runs external bus cycles. Each request carries an area number, a direction flag and a flag that marks a single-address transfer. The requester holds a request until the block grants it. For external requests, the block compares the request with the last external access it granted. When one of the enabled conditions matches, it places a programmable number of idle states between the two bus cycles. This stops a device that releases the data bus slowly from overlapping with the next, faster device.

Three conditions build on each other, and configuration enables them as a set. Condition A covers a change of area between two reads, and any external access that follows a single-address transfer. Condition B adds a write that follows a read. Condition C adds a read that follows a write. A second configuration field sets the gap length, from one to four idle states. Internal accesses pass straight through. They never receive idle states and do not change the stored previous-access record.

Top module: `ebus_idle_gap`

## Requirements
- R1: After reset, `idle_busy` and `cyc_start` are low. The first external access after reset is granted with `cyc_start` in its first request cycle, whatever the configuration.
- R2: A request with `req_ext` low is granted in its first cycle, with `cyc_start` and `idle_busy` low. It leaves the previous-access record unchanged.
- R3: With `cfg_cond_sel` = 2'b00, no idle state is ever inserted.
- R4: With `cfg_cond_sel` of 2'b01 or above, a read that follows a read to a different area gets idle states. A read that follows a read to the same area gets none.
- R5: With `cfg_cond_sel` of 2'b01 or above, any external access that follows an external access flagged by `req_single_addr` gets idle states, whatever its direction or area.
- R6: A write that follows a read gets idle states only when `cfg_cond_sel` is 2'b10 or 2'b11.
- R7: A read that follows a write gets idle states only when `cfg_cond_sel` is 2'b11.
- R8: A write that follows a write (not single-address) never gets idle states.
- R9: When idle states are inserted, the flow is as follows. The first request cycle shows neither grant nor busy. `idle_busy` is then high for exactly `cfg_idle_cnt`+1 cycles (code 2'b00 means one state, 2'b11 means four). `cyc_start` and `req_ready` are asserted on the cycle after the last idle state.
- R10: While `idle_busy` is high, `cyc_start` and `req_ready` stay low.
- R11: `cyc_start` is asserted only together with `req_ready`, for a valid external request. A grant without inserted idle states is combinational, in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cond_sel | input | 2 | Condition set: 00 none, 01 A, 10 A+B, 11 A+B+C |
| cfg_idle_cnt | input | IDLE_CFG_W | Idle states minus one |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_ext | input | 1 | Request targets external space |
| req_area | input | AREA_W | Area number of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_single_addr | input | 1 | Request is a single-address transfer |
| req_ready | output | 1 | Request granted this cycle |
| cyc_start | output | 1 | External bus cycle starts this cycle |
| idle_busy | output | 1 | Idle state in progress |

## Verification
The bench builds the block with `NUM_AREAS` = 4, so the area field is two bits wide, and keeps the default two-bit idle-count field. At this size the bench can sweep everything that matters. It covers every condition-select code, every idle count, every previous record (four areas, both directions, with and without the single-address flag) and every following external request. Each condition therefore meets each enable level and each gap length. Separate sequences cover the first access after reset, and an internal access placed between two reads to the same area.

// File: rtl/ebig_pkg.sv
package ebig_pkg;

   typedef enum logic [1:0] {
      ST_OPEN   = 2'd0,
      ST_GAP    = 2'd1,
      ST_LAUNCH = 2'd2
   } ebig_state_e;

   localparam logic [1:0] SEL_NONE = 2'b00;
   localparam logic [1:0] SEL_A    = 2'b01;
   localparam logic [1:0] SEL_AB   = 2'b10;
   localparam logic [1:0] SEL_ABC  = 2'b11;

endpackage

// File: rtl/ebig_prev_rec.sv
module ebig_prev_rec #(
   parameter int AREA_W     = 3,
   parameter bit TRACK_AREA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [AREA_W-1:0] in_area,
   input  logic              in_write,
   input  logic              in_single,
   output logic              prv_valid,
   output logic [AREA_W-1:0] prv_area,
   output logic              prv_write,
   output logic              prv_single
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prv_valid  <= 1'b0;
         prv_write  <= 1'b0;
         prv_single <= 1'b0;
      end else if (upd) begin
         prv_valid  <= 1'b1;
         prv_write  <= in_write;
         prv_single <= in_single;
      end
   end

   generate
      if (TRACK_AREA) begin : g_area
         logic [AREA_W-1:0] area_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   area_q <= '0;
            else if (upd) area_q <= in_area;
         end
         assign prv_area = area_q;
      end else begin : g_no_area
         logic unused_area;
         assign unused_area = ^in_area;
         assign prv_area    = '0;
      end
   endgenerate

endmodule

// File: rtl/ebig_cond_eval.sv
module ebig_cond_eval
   import ebig_pkg::*;
#(
   parameter int AREA_W = 3
) (
   input  logic [1:0]        sel,
   input  logic              cur_ext,
   input  logic [AREA_W-1:0] cur_area,
   input  logic              cur_write,
   input  logic              prv_valid,
   input  logic [AREA_W-1:0] prv_area,
   input  logic              prv_write,
   input  logic              prv_single,
   output logic              need_gap
);

   logic area_diff;
   logic hit_a, hit_b, hit_c;
   logic en_a, en_b, en_c;

   always_comb begin
      area_diff = (cur_area != prv_area);
      hit_a = (!cur_write && !prv_write && area_diff) || prv_single;
      hit_b = !prv_write && cur_write;
      hit_c = prv_write && !cur_write;
      en_a  = (sel != SEL_NONE);
      en_b  = (sel == SEL_AB) || (sel == SEL_ABC);
      en_c  = (sel == SEL_ABC);
      need_gap = cur_ext && prv_valid &&
                 ((en_a && hit_a) || (en_b && hit_b) || (en_c && hit_c));
   end

endmodule

// File: rtl/ebig_gap_ctr.sv
module ebig_gap_ctr
   import ebig_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_ext,
   input  logic             need_gap,
   input  logic [CNT_W-1:0] gap_len_m1,
   output logic             grant,
   output logic             start,
   output logic             busy
);

   ebig_state_e      state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      grant   = 1'b0;
      start   = 1'b0;
      busy    = (state_q == ST_GAP);
      unique case (state_q)
         ST_OPEN: begin
            if (req_valid) begin
               if (req_ext && need_gap) begin
                  state_d = ST_GAP;
                  cnt_d   = gap_len_m1;
               end else begin
                  grant = 1'b1;
                  start = req_ext;
               end
            end
         end
         ST_GAP: begin
            if (cnt_q == '0) state_d = ST_LAUNCH;
            else             cnt_d   = cnt_q - 1'b1;
         end
         ST_LAUNCH: begin
            if (req_valid) begin
               grant   = 1'b1;
               start   = req_ext;
               state_d = ST_OPEN;
            end
         end
         default: state_d = ST_OPEN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OPEN;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

endmodule

// File: rtl/ebus_idle_gap.sv
module ebus_idle_gap #(
   parameter int NUM_AREAS  = 8,
   parameter int IDLE_CFG_W = 2,
   localparam int AREA_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            cfg_cond_sel,
   input  logic [IDLE_CFG_W-1:0] cfg_idle_cnt,
   input  logic                  req_valid,
   input  logic                  req_ext,
   input  logic [AREA_W-1:0]     req_area,
   input  logic                  req_write,
   input  logic                  req_single_addr,
   output logic                  req_ready,
   output logic                  cyc_start,
   output logic                  idle_busy
);

   localparam bit TRACK_AREA = (NUM_AREAS > 1);

   generate
      if (NUM_AREAS < 1) begin : g_bad_areas
         $error("ebus_idle_gap: NUM_AREAS must be at least 1");
      end
      if (IDLE_CFG_W < 1 || IDLE_CFG_W > 4) begin : g_bad_cnt
         $error("ebus_idle_gap: IDLE_CFG_W must be 1..4");
      end
   endgenerate

   logic              prv_valid, prv_write, prv_single;
   logic [AREA_W-1:0] prv_area;
   logic              need_gap;

   ebig_prev_rec #(
      .AREA_W     (AREA_W),
      .TRACK_AREA (TRACK_AREA)
   ) u_rec (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd        (cyc_start),
      .in_area    (req_area),
      .in_write   (req_write),
      .in_single  (req_single_addr),
      .prv_valid  (prv_valid),
      .prv_area   (prv_area),
      .prv_write  (prv_write),
      .prv_single (prv_single)
   );

   ebig_cond_eval #(
      .AREA_W (AREA_W)
   ) u_eval (
      .sel        (cfg_cond_sel),
      .cur_ext    (req_ext),
      .cur_area   (req_area),
      .cur_write  (req_write),
      .prv_valid  (prv_valid),
      .prv_area   (prv_area),
      .prv_write  (prv_write),
      .prv_single (prv_single),
      .need_gap   (need_gap)
   );

   ebig_gap_ctr #(
      .CNT_W (IDLE_CFG_W)
   ) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ext    (req_ext),
      .need_gap   (need_gap),
      .gap_len_m1 (cfg_idle_cnt),
      .grant      (req_ready),
      .start      (cyc_start),
      .busy       (idle_busy)
   );

endmodule

// File: rtl/ebig_idle_gap_chk.sv
module ebig_idle_gap_chk #(
   parameter int IDLE_CFG_W = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_cond_sel,
   input logic       req_valid,
   input logic       req_ext,
   input logic       req_ready,
   input logic       cyc_start,
   input logic       idle_busy
);

   localparam int MAX_IDLE = 1 << IDLE_CFG_W;

   int run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_q <= 0;
      else if (idle_busy) run_q <= run_q + 1;
      else                run_q <= 0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (!idle_busy && !cyc_start || !req_valid)
            else $error("R1: busy or start during reset");
      end
   end

   a_r10_gap_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
      idle_busy |-> (!cyc_start && !req_ready));

   a_r11_start_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |-> (req_ready && req_valid && req_ext));

   a_r2_internal_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ext && !idle_busy) |-> (req_ready && !cyc_start));

   a_r9_start_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle_busy) |-> cyc_start);

   a_r9_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
      idle_busy |-> (run_q < MAX_IDLE));

   a_r3_sel_off_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cond_sel == 2'b00 && req_valid && !idle_busy && !$past(idle_busy))
         |-> req_ready);

endmodule

bind ebus_idle_gap ebig_idle_gap_chk #(
   .IDLE_CFG_W (IDLE_CFG_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_cond_sel (cfg_cond_sel),
   .req_valid    (req_valid),
   .req_ext      (req_ext),
   .req_ready    (req_ready),
   .cyc_start    (cyc_start),
   .idle_busy    (idle_busy)
);

// File: tb/ebus_idle_gap_bench.sv
`timescale 1ns/1ps
module ebus_idle_gap_bench;

   localparam int NA = 4;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cfg_cond_sel = 2'b00;
   logic [1:0]    cfg_idle_cnt = 2'b00;
   logic          req_valid = 1'b0;
   logic          req_ext = 1'b0;
   logic [AW-1:0] req_area = '0;
   logic          req_write = 1'b0;
   logic          req_single_addr = 1'b0;
   logic          req_ready, cyc_start, idle_busy;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   ebus_idle_gap #(.NUM_AREAS(NA), .IDLE_CFG_W(2)) u_ebus_idle_gap (
      .clk(clk), .rst_n(rst_n), .cfg_cond_sel(cfg_cond_sel),
      .cfg_idle_cnt(cfg_idle_cnt), .req_valid(req_valid), .req_ext(req_ext),
      .req_area(req_area), .req_write(req_write),
      .req_single_addr(req_single_addr), .req_ready(req_ready),
      .cyc_start(cyc_start), .idle_busy(idle_busy));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
         finish_run();
      end
   end

   // Issues one request and holds it until granted.
   // busy_n: cycles with idle_busy high; wait_n: cycles without grant.
   task automatic access(input int area, input bit wr, input bit sa, input bit ext,
                         output int busy_n, output int wait_n, output int st);
      busy_n = 0;
      wait_n = 0;
      st     = 0;
      @(negedge clk);
      req_area        = AW'(area);
      req_write       = wr;
      req_single_addr = sa;
      req_ext         = ext;
      req_valid       = 1'b1;
      #1;
      for (int k = 0; k < 12; k++) begin
         if (req_ready) begin
            st = int'(cyc_start);
            break;
         end
         if (idle_busy) busy_n++;
         if (cyc_start) begin
            n_chk++; n_bad++;
            $display("FAIL R10 actual=start_without_grant expected=no_start");
         end
         wait_n++;
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   function automatic bit exp_need(input int sel, input int pa, input bit pw,
                                   input bit psa, input int ca, input bit cw);
      bit a, b, c;
      a = (!cw && !pw && ca != pa) || psa;
      b = !pw && cw;
      c = pw && !cw;
      return (sel >= 1 && a) || (sel >= 2 && b) || (sel == 3 && c);
   endfunction

   function automatic string tag_of(input int sel, input bit pw, input bit psa,
                                    input bit cw);
      if (sel == 0)       return "R3";
      if (psa)            return "R5";
      if (!pw && !cw)     return "R4";
      if (!pw && cw)      return "R6";
      if (pw && !cw)      return "R7";
      return "R8";
   endfunction

   initial begin
      int bn, wn, st;
      #12;
      // R1: reset state
      chk("R1 busy in reset", int'(idle_busy), 0);
      chk("R1 start in reset", int'(cyc_start), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cfg_cond_sel = 2'b11;
      cfg_idle_cnt = 2'b11;
      @(negedge clk);
      chk("R1 busy after reset", int'(idle_busy), 0);
      access(2, 1'b1, 1'b1, 1'b1, bn, wn, st);
      chk("R1 first access wait", wn, 0);
      chk("R1 first access start", st, 1);

      // R2: internal access passes and leaves record alone
      cfg_cond_sel = 2'b01;
      cfg_idle_cnt = 2'b01;
      access(0, 1'b0, 1'b0, 1'b1, bn, wn, st);
      access(3, 1'b0, 1'b0, 1'b0, bn, wn, st);
      chk("R2 internal wait", wn, 0);
      chk("R2 internal start", st, 0);
      chk("R2 internal busy", bn, 0);
      access(0, 1'b0, 1'b0, 1'b1, bn, wn, st);
      chk("R2 record unchanged wait", wn, 0);
      chk("R2 record unchanged start", st, 1);

      // Sweep: every select, count, previous record and next request
      for (int sel = 0; sel < 4; sel++) begin
         for (int cn = 0; cn < 4; cn++) begin
            for (int pa = 0; pa < NA; pa++) begin
               for (int pw = 0; pw < 2; pw++) begin
                  for (int ps = 0; ps < 2; ps++) begin
                     for (int ca = 0; ca < NA; ca++) begin
                        for (int cw = 0; cw < 2; cw++) begin
                           bit    nd;
                           string tg;
                           cfg_cond_sel = 2'(sel);
                           cfg_idle_cnt = 2'(cn);
                           access(pa, pw[0], ps[0], 1'b1, bn, wn, st);
                           access(ca, cw[0], 1'b0, 1'b1, bn, wn, st);
                           nd = exp_need(sel, pa, pw[0], ps[0], ca, cw[0]);
                           tg = tag_of(sel, pw[0], ps[0], cw[0]);
                           chk($sformatf("%s R9 busy sel=%0d cnt=%0d pa=%0d pw=%0d ps=%0d ca=%0d cw=%0d",
                                         tg, sel, cn, pa, pw, ps, ca, cw),
                               bn, nd ? cn + 1 : 0);
                           chk($sformatf("%s R9 wait sel=%0d cnt=%0d", tg, sel, cn),
                               wn, nd ? cn + 2 : 0);
                           chk($sformatf("%s R11 start", tg), st, 1);
                        end
                     end
                  end
               end
            end
         end
      end
      finish_run();
   end

endmodule